// File: doc/BRIEF.md
# Page Translation Unit with Tagged Lookup Cache

This block turns virtual addresses from a processor into physical addresses, using pages of one fixed size. The upper bits of a virtual address are the page number and the lower bits are the in-page offset. A small, fully associative lookup cache holds recent translations. Each cache entry is tagged with an address-space tag. When the cache misses, the unit fetches the table entry for the page from a single-level table in memory. The table's start address and its length come from configuration registers. Each answer is either a physical address or a fault code.

Control is a two-state machine. In `ST_IDLE` the request port is ready. An accepted request that is out of range, or that hits the cache, is answered in the following cycle, and the machine stays in `ST_IDLE`. An accepted in-range miss takes the transition IDLE→FETCH. In `ST_FETCH` the unit holds a table read request and its request port is not ready. It stays in `ST_FETCH` while the read has not been acknowledged. The acknowledge takes the transition FETCH→IDLE: the answer appears in the next cycle and, for a valid table entry, the translation is installed in the cache.

The configuration port writes three registers. Select 0 is the table base, a word address. Select 1 is the table length, in pages. Select 2 is the current address-space tag. Writes to the table base or the table length invalidate the whole cache. A write to the tag register does not, so translations from several address spaces can live side by side in the cache.

Top module: `pg_xlate_mmu`

## Requirements
- R1: A successful translation returns `{frame, vaddr[PAGE_BITS-1:0]}`. The offset passes through unchanged and the frame fills the upper `PA_W-PAGE_BITS` bits. `PAGE_BITS` must lie between 9 and 13.
- R2: A request that hits the cache is answered with `rsp_valid` one cycle after it is accepted. No table read takes place and `req_ready` stays high.
- R3: A hit requires a cache entry whose page number and address-space tag both equal the request page number and the current tag register. An entry filled under another tag causes a table read.
- R4: On an in-range miss, `mem_rd_req` rises in the cycle after acceptance with `mem_rd_addr = base + page number` (modulo `2^MEM_AW`). It stays high with a stable address until `mem_rd_ack`. `req_ready` is low throughout. The answer follows one cycle after the acknowledge.
- R5: A page number at or above the length register is answered one cycle after acceptance with fault code 1, with no table read. Whenever any fault is returned, `rsp_paddr` is zero.
- R6: Table entry layout: bit `FRAME_W+1` is valid, bit `FRAME_W` is write-permit, and bits `FRAME_W-1:0` are the frame. An entry with valid at 0 returns fault code 2 and is not installed, so a repeat access reads the table again.
- R7: A write access (`req_wr`=1) to a page whose write-permit bit is 0 returns fault code 3, on both the hit and the walk path. A read of the same page succeeds.
- R8: A walk that reads a valid entry installs it, so the next access to that page under the same tag is a hit.
- R9: Fills go to a round-robin victim slot. With `TLB_N` entries, the (`TLB_N`+1)th fill after a flush evicts the first one filled.
- R10: A high `flush` cycle invalidates every entry. The next access to any page performs a table read.
- R11: A configuration write with select 0 or 1 invalidates every entry. A write with select 2 keeps the entries. Select 3 is ignored and changes no register.
- R12: After reset: `req_ready`=1, `rsp_valid`=0, `mem_rd_req`=0, base=0, length=0, tag=0, and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 length, 2 tag, 3 none |
| cfg_wdata | input | MEM_AW | Configuration write data (low bits used for length and tag) |
| flush | input | 1 | Invalidate all cache entries |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | VA_W | Virtual address |
| req_wr | input | 1 | Access type: 1 write, 0 read |
| rsp_valid | output | 1 | One-cycle answer strobe |
| rsp_paddr | output | PA_W | Physical address, zero on fault |
| rsp_fault | output | 2 | 0 none, 1 out of range, 2 invalid entry, 3 write denied |
| mem_rd_req | output | 1 | Table read request |
| mem_rd_addr | output | MEM_AW | Table entry word address |
| mem_rd_ack | input | 1 | Read completes; data valid this cycle |
| mem_rd_data | input | PA_W-PAGE_BITS+2 | Table entry |

## Verification
Hits and range faults are due exactly one cycle after acceptance. The bench samples on the first falling edge after the accepting rising edge and requires `rsp_valid` there, with no table read seen. A walk's answer is due one cycle after the acknowledge edge, however long the memory model stalls: the bench records the acknowledge level on each falling edge and requires it to have been high on the falling edge just before the one where `rsp_valid` is first seen. A reference cache model with its own round-robin pointer predicts, for each request, whether a walk happens, which address is read and the resulting address or fault.

// File: rtl/pg_xlate_pkg.sv
package pg_xlate_pkg;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_RANGE   = 2'd1,
        FLT_INVALID = 2'd2,
        FLT_WPROT   = 2'd3
    } fault_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } walk_state_e;

    localparam logic [1:0] CFG_BASE = 2'd0;
    localparam logic [1:0] CFG_LEN  = 2'd1;
    localparam logic [1:0] CFG_ASID = 2'd2;

endpackage

// File: rtl/pg_cfg_regs.sv
module pg_cfg_regs
    import pg_xlate_pkg::*;
#(
    parameter int MEM_AW = 16,
    parameter int LEN_W  = 8,
    parameter int ASID_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [MEM_AW-1:0] wdata,
    output logic [MEM_AW-1:0] base,
    output logic [LEN_W-1:0]  len,
    output logic [ASID_W-1:0] asid,
    output logic              inval
);

    // base/length changes make cached translations stale; tag changes do not
    assign inval = we && ((sel == CFG_BASE) || (sel == CFG_LEN));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
            len  <= '0;
            asid <= '0;
        end else if (we) begin
            if (sel == CFG_BASE) base <= wdata;
            if (sel == CFG_LEN)  len  <= wdata[LEN_W-1:0];
            if (sel == CFG_ASID) asid <= wdata[ASID_W-1:0];
        end
    end

endmodule

// File: rtl/pg_tlb.sv
module pg_tlb #(
    parameter int N       = 4,
    parameter int VPN_W   = 7,
    parameter int ASID_W  = 4,
    parameter int FRAME_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [ASID_W-1:0]  lk_asid,
    output logic               lk_hit,
    output logic [FRAME_W-1:0] lk_frame,
    output logic               lk_wok,
    input  logic               fill_en,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [ASID_W-1:0]  fill_asid,
    input  logic [FRAME_W-1:0] fill_frame,
    input  logic               fill_wok
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]       ent_v;
    logic [VPN_W-1:0]   ent_vpn   [N];
    logic [ASID_W-1:0]  ent_asid  [N];
    logic [FRAME_W-1:0] ent_frame [N];
    logic               ent_wok   [N];
    logic [N-1:0]       match;
    logic [IDX_W-1:0]   victim;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = ent_v[i] && (ent_vpn[i] == lk_vpn) && (ent_asid[i] == lk_asid);
    end

    always_comb begin
        lk_hit   = |match;
        lk_frame = '0;
        lk_wok   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) begin
                lk_frame = lk_frame | ent_frame[i];
                lk_wok   = lk_wok | ent_wok[i];
            end
        end
    end

    // flush wins over a fill in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v  <= '0;
            victim <= '0;
        end else if (flush) begin
            ent_v <= '0;
        end else if (fill_en) begin
            ent_v[victim]     <= 1'b1;
            ent_vpn[victim]   <= fill_vpn;
            ent_asid[victim]  <= fill_asid;
            ent_frame[victim] <= fill_frame;
            ent_wok[victim]   <= fill_wok;
            victim <= (victim == IDX_W'(N - 1)) ? '0 : victim + 1'b1;
        end
    end

endmodule

// File: rtl/pg_xlate_mmu.sv
module pg_xlate_mmu
    import pg_xlate_pkg::*;
#(
    parameter int VA_W      = 16,
    parameter int PAGE_BITS = 9,
    parameter int PA_W      = 20,
    parameter int ASID_W    = 4,
    parameter int TLB_N     = 4,
    parameter int MEM_AW    = 16,
    localparam int FRAME_W  = PA_W - PAGE_BITS,
    localparam int PTE_W    = FRAME_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [MEM_AW-1:0] cfg_wdata,
    input  logic              flush,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_wr,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_fault,
    output logic              mem_rd_req,
    output logic [MEM_AW-1:0] mem_rd_addr,
    input  logic              mem_rd_ack,
    input  logic [PTE_W-1:0]  mem_rd_data
);

    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int LEN_W = VPN_W + 1;

    if (PAGE_BITS < 9 || PAGE_BITS > 13) begin : g_bad_page
        $error("PAGE_BITS out of range");
    end

    walk_state_e st, st_nx;

    logic [MEM_AW-1:0]    tbl_base;
    logic [LEN_W-1:0]     tbl_len;
    logic [ASID_W-1:0]    cur_asid;
    logic                 cfg_inval;
    logic                 tlb_flush;
    logic                 tlb_hit;
    logic [FRAME_W-1:0]   tlb_frame;
    logic                 tlb_wok;
    logic                 fill_en;

    logic [VPN_W-1:0]     vpn;
    logic [PAGE_BITS-1:0] off;
    logic                 oob;
    logic                 accept;

    logic [VPN_W-1:0]     w_vpn;
    logic [PAGE_BITS-1:0] w_off;
    logic                 w_wr;
    logic [ASID_W-1:0]    w_asid;
    logic [MEM_AW-1:0]    w_addr;

    logic                 pte_v;
    logic                 pte_w;
    logic [FRAME_W-1:0]   pte_frame;

    assign vpn    = req_vaddr[VA_W-1:PAGE_BITS];
    assign off    = req_vaddr[PAGE_BITS-1:0];
    assign oob    = {1'b0, vpn} >= tbl_len;
    assign accept = req_valid && (st == ST_IDLE);

    assign pte_v     = mem_rd_data[FRAME_W+1];
    assign pte_w     = mem_rd_data[FRAME_W];
    assign pte_frame = mem_rd_data[FRAME_W-1:0];

    assign tlb_flush = flush || cfg_inval;
    assign fill_en   = (st == ST_FETCH) && mem_rd_ack && pte_v;

    assign req_ready   = (st == ST_IDLE);
    assign mem_rd_req  = (st == ST_FETCH);
    assign mem_rd_addr = w_addr;

    pg_cfg_regs #(
        .MEM_AW (MEM_AW),
        .LEN_W  (LEN_W),
        .ASID_W (ASID_W)
    ) cfg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .base  (tbl_base),
        .len   (tbl_len),
        .asid  (cur_asid),
        .inval (cfg_inval)
    );

    pg_tlb #(
        .N       (TLB_N),
        .VPN_W   (VPN_W),
        .ASID_W  (ASID_W),
        .FRAME_W (FRAME_W)
    ) tlb_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (tlb_flush),
        .lk_vpn     (vpn),
        .lk_asid    (cur_asid),
        .lk_hit     (tlb_hit),
        .lk_frame   (tlb_frame),
        .lk_wok     (tlb_wok),
        .fill_en    (fill_en),
        .fill_vpn   (w_vpn),
        .fill_asid  (w_asid),
        .fill_frame (pte_frame),
        .fill_wok   (pte_w)
    );

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (accept && !oob && !tlb_hit) st_nx = ST_FETCH;
            ST_FETCH: if (mem_rd_ack) st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // walk context captured at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_vpn  <= '0;
            w_off  <= '0;
            w_wr   <= 1'b0;
            w_asid <= '0;
            w_addr <= '0;
        end else if (accept) begin
            w_vpn  <= vpn;
            w_off  <= off;
            w_wr   <= req_wr;
            w_asid <= cur_asid;
            w_addr <= tbl_base + MEM_AW'(vpn);
        end
    end

    // registered answer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= FLT_NONE;
        end else begin
            rsp_valid <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (accept && oob) begin
                        rsp_valid <= 1'b1;
                        rsp_fault <= FLT_RANGE;
                        rsp_paddr <= '0;
                    end else if (accept && tlb_hit) begin
                        rsp_valid <= 1'b1;
                        if (req_wr && !tlb_wok) begin
                            rsp_fault <= FLT_WPROT;
                            rsp_paddr <= '0;
                        end else begin
                            rsp_fault <= FLT_NONE;
                            rsp_paddr <= {tlb_frame, off};
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_rd_ack) begin
                        rsp_valid <= 1'b1;
                        if (!pte_v) begin
                            rsp_fault <= FLT_INVALID;
                            rsp_paddr <= '0;
                        end else if (w_wr && !pte_w) begin
                            rsp_fault <= FLT_WPROT;
                            rsp_paddr <= '0;
                        end else begin
                            rsp_fault <= FLT_NONE;
                            rsp_paddr <= {pte_frame, w_off};
                        end
                    end
                end
                default: rsp_valid <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pg_xlate_mmu_chk.sv
module pg_xlate_mmu_chk
    import pg_xlate_pkg::*;
#(
    parameter int PA_W   = 20,
    parameter int MEM_AW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              accept,
    input logic              oob,
    input logic              tlb_hit,
    input logic              tlb_flush,
    input logic              rsp_valid,
    input logic [1:0]        rsp_fault,
    input logic [PA_W-1:0]   rsp_paddr,
    input logic              mem_rd_req,
    input logic              mem_rd_ack,
    input logic [MEM_AW-1:0] mem_rd_addr
);

    p_hit_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !oob && tlb_hit) |=> (rsp_valid && !mem_rd_req && req_ready));

    p_range_noread_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && oob) |=> (rsp_valid && rsp_fault == FLT_RANGE && !mem_rd_req));

    p_fault_zero_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0));

    p_walk_not_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !req_ready);

    p_read_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

    p_ack_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_ack) |=> (rsp_valid && !mem_rd_req));

    // R10 and R11: any invalidation leaves no entry that can hit
    p_inval_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush |=> !tlb_hit);

endmodule

bind pg_xlate_mmu pg_xlate_mmu_chk #(
    .PA_W   (PA_W),
    .MEM_AW (MEM_AW)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .accept      (accept),
    .oob         (oob),
    .tlb_hit     (tlb_hit),
    .tlb_flush   (tlb_flush),
    .rsp_valid   (rsp_valid),
    .rsp_fault   (rsp_fault),
    .rsp_paddr   (rsp_paddr),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_ack  (mem_rd_ack),
    .mem_rd_addr (mem_rd_addr)
);

// File: tb/pg_xlate_mmu_tb_top.sv
module pg_xlate_mmu_tb_top;
    import pg_xlate_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int VA_W = 16, PAGE_BITS = 9, PA_W = 20, ASID_W = 4, TLB_N = 4, MEM_AW = 16;
    localparam int FRAME_W = PA_W - PAGE_BITS;
    localparam int PTE_W = FRAME_W + 2;
    localparam int VPN_W = VA_W - PAGE_BITS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [MEM_AW-1:0] cfg_wdata = '0;
    logic flush = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [VA_W-1:0] req_vaddr = '0;
    logic req_wr = 1'b0;
    logic rsp_valid;
    logic [PA_W-1:0] rsp_paddr;
    logic [1:0] rsp_fault;
    logic mem_rd_req;
    logic [MEM_AW-1:0] mem_rd_addr;
    logic mem_rd_ack = 1'b0;
    logic [PTE_W-1:0] mem_rd_data = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pg_xlate_mmu dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .flush(flush), .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_wr(req_wr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
        .mem_rd_data(mem_rd_data)
    );

    int checks = 0;
    int fails = 0;

    // reference state
    logic [MEM_AW-1:0]  m_base = '0;
    int                 m_len = 0;
    logic [ASID_W-1:0]  m_asid = '0;
    bit                 m_v  [TLB_N];
    int                 m_vpn[TLB_N];
    logic [ASID_W-1:0]  m_as [TLB_N];
    logic [FRAME_W-1:0] m_fr [TLB_N];
    bit                 m_w  [TLB_N];
    int                 m_ptr = 0;

    // responder observations
    bit                rd_seen = 1'b0;
    logic [MEM_AW-1:0] rd_addr = '0;
    int                dly = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [PTE_W-1:0] pte_of(input logic [MEM_AW-1:0] a);
        logic v, w;
        logic [FRAME_W-1:0] fr;
        v  = ((int'(a) % 7) != 3);
        w  = a[1];
        fr = FRAME_W'((int'(a) * 29 + 11));
        return {v, w, fr};
    endfunction

    function automatic void model_clear();
        for (int i = 0; i < TLB_N; i++) m_v[i] = 1'b0;
    endfunction

    // memory model: variable stall, acknowledge held for one cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mem_rd_ack) begin
                mem_rd_ack = 1'b0;
            end else if (mem_rd_req) begin
                if (dly == 0) begin
                    mem_rd_ack  = 1'b1;
                    mem_rd_data = pte_of(mem_rd_addr);
                    rd_seen     = 1'b1;
                    rd_addr     = mem_rd_addr;
                end else begin
                    dly--;
                end
            end else begin
                dly = int'($urandom % 4);
            end
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [MEM_AW-1:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (sel == CFG_BASE) begin m_base = val; model_clear(); end
        if (sel == CFG_LEN)  begin m_len = int'(val[VPN_W:0]); model_clear(); end
        if (sel == CFG_ASID) m_asid = val[ASID_W-1:0];
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk); #1;
        flush = 1'b0;
        model_clear();
    endtask

    task automatic do_req(input int vpn, input int off, input bit wr, input string tag);
        int idx, n;
        bit e_walk, got, prev_ack, ready_bad;
        logic [1:0] e_f;
        logic [PA_W-1:0] e_pa;
        logic [FRAME_W-1:0] fr;
        logic [MEM_AW-1:0] e_addr;
        logic [PTE_W-1:0] pte;
        bit w, v;
        // expected result
        e_walk = 1'b0; e_addr = '0; e_pa = '0; fr = '0; w = 1'b0; v = 1'b1;
        idx = -1;
        if (vpn >= m_len) begin
            e_f = FLT_RANGE;
        end else begin
            for (int i = 0; i < TLB_N; i++)
                if (m_v[i] && m_vpn[i] == vpn && m_as[i] == m_asid) idx = i;
            if (idx >= 0) begin
                fr = m_fr[idx]; w = m_w[idx];
            end else begin
                e_walk = 1'b1;
                e_addr = m_base + MEM_AW'(vpn);
                pte = pte_of(e_addr);
                v = pte[FRAME_W+1]; w = pte[FRAME_W]; fr = pte[FRAME_W-1:0];
                if (v) begin
                    m_v[m_ptr] = 1'b1; m_vpn[m_ptr] = vpn; m_as[m_ptr] = m_asid;
                    m_fr[m_ptr] = fr; m_w[m_ptr] = w;
                    m_ptr = (m_ptr + 1) % TLB_N;
                end
            end
            if (!v)           e_f = FLT_INVALID;
            else if (wr && !w) e_f = FLT_WPROT;
            else begin
                e_f = FLT_NONE;
                e_pa = {fr, PAGE_BITS'(off)};
            end
        end
        // drive
        @(negedge clk);
        rd_seen = 1'b0;
        req_valid = 1'b1;
        req_vaddr = {VPN_W'(vpn), PAGE_BITS'(off)};
        req_wr = wr;
        @(posedge clk); #1;
        req_valid = 1'b0;
        n = 0; got = 1'b0; prev_ack = 1'b0; ready_bad = 1'b0;
        while (n < 40 && !got) begin
            @(negedge clk);
            n++;
            if (rsp_valid) got = 1'b1;
            else begin
                prev_ack = mem_rd_ack;
                if (mem_rd_req && req_ready) ready_bad = 1'b1;
            end
        end
        chk(got, tag, "answer present", got, 1);
        chk(rsp_fault == e_f, tag, "fault code", rsp_fault, e_f);
        chk(rsp_paddr == e_pa, tag, "physical address", rsp_paddr, e_pa);
        chk(rd_seen == e_walk, tag, "table read occurred", rd_seen, e_walk);
        if (e_walk) begin
            chk(rd_addr == e_addr, tag, "table read address", rd_addr, e_addr);
            chk(prev_ack, tag, "answer one cycle after ack", prev_ack, 1);
            chk(!ready_bad, tag, "ready low during walk", ready_bad, 0);
        end else begin
            chk(n == 1, tag, "answer one cycle after accept", n, 1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(req_ready == 1'b1, "R12", "req_ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R12", "rsp_valid after reset", rsp_valid, 0);
        chk(mem_rd_req == 1'b0, "R12", "mem_rd_req after reset", mem_rd_req, 0);
        do_req(0, 0, 1'b0, "R12");          // length resets to 0: range fault

        cfg_write(CFG_BASE, 16'h0100);
        cfg_write(CFG_LEN, 16'd64);
        cfg_write(CFG_ASID, 16'd3);

        do_req(5, 9'h0A3, 1'b0, "R4");      // walk
        do_req(5, 9'h1FF, 1'b0, "R2");      // hit
        do_req(5, 9'h000, 1'b0, "R1");      // offset pass-through
        do_req(64, 9'h010, 1'b0, "R5");     // first illegal page
        do_req(127, 9'h1FF, 1'b0, "R5");
        do_req(63, 9'h004, 1'b0, "R5");     // last legal page
        do_req(6, 9'h020, 1'b0, "R6");      // invalid entry
        do_req(6, 9'h020, 1'b0, "R6");      // not installed: walks again
        do_req(5, 9'h011, 1'b1, "R7");      // write to read-only, hit path
        do_req(2, 9'h033, 1'b1, "R7");      // writable page
        do_req(9, 9'h044, 1'b1, "R7");      // write to read-only, walk path
        do_req(9, 9'h045, 1'b0, "R8");      // installed despite write fault

        do_flush();
        do_req(5, 9'h001, 1'b0, "R10");     // walks after flush
        cfg_write(CFG_ASID, 16'd4);
        do_req(5, 9'h002, 1'b0, "R3");      // other tag: walk
        cfg_write(CFG_ASID, 16'd3);
        do_req(5, 9'h003, 1'b0, "R3");      // original tag entry kept
        do_req(5, 9'h004, 1'b0, "R11");     // tag write kept entries
        cfg_write(2'd3, 16'h0000);
        do_req(5, 9'h005, 1'b0, "R11");     // select 3 ignored: still hit
        do_req(40, 9'h006, 1'b0, "R11");    // length untouched
        cfg_write(CFG_LEN, 16'd64);
        do_req(5, 9'h007, 1'b0, "R11");     // length write invalidated

        do_flush();
        for (int p = 28; p <= 32; p++) do_req(p, p, 1'b0, "R9");
        do_req(29, 9'h001, 1'b0, "R9");
        do_req(31, 9'h002, 1'b0, "R9");
        do_req(28, 9'h003, 1'b0, "R9");     // oldest was evicted

        for (int k = 0; k < 400; k++) begin
            int r;
            r = int'($urandom % 20);
            if (r == 0) do_flush();
            else if (r == 1) cfg_write(CFG_ASID, MEM_AW'($urandom % 4));
            else if (r == 2) cfg_write(CFG_LEN, MEM_AW'(8 + $urandom % 64));
            else if (r == 3) do_req(int'($urandom % 128), int'($urandom % 512), 1'(($urandom % 2)), "R5");
            else do_req(int'($urandom % 12), int'($urandom % 512), 1'(($urandom % 2)), "R8");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule